// File: doc/BRIEF.md
# Preamble and Header Bit Generator

This block produces the uncoded transmit bit stream that opens every physical-layer frame, ahead of the scrambler. One frame consists of four parts: a synchronisation field, a 16-bit start-of-frame delimiter, a 32-bit header, and a 16-bit header check. The header carries a signal byte, a service byte and a 16-bit length word. The check is a CRC-16 that the block computes on the fly as the header bits leave. A mode input selects between two formats. In long format the sync field is a run of ones whose length comes from configuration. In short format the sync field is a fixed run of zeros, the delimiter is bit-reversed, and the header is tagged for the doubled rate.

The block emits bits on a valid/ready stream. Each bit carries a rate tag alongside it. The stream follows back-pressure rules: once `bit_valid` is high it stays high, and `bit_data` and `bit_rate` stay unchanged, until a cycle in which `bit_ready` is also high. Exactly one bit is consumed per such handshake. The consumer may hold `bit_ready` low for any number of cycles. After the last check bit is accepted, a one-cycle `done` pulse tells the payload path to take over.

Top module: `preamble_header_gen`

## Requirements
- R1: After reset, `bit_valid`, `busy` and `done` are low.
- R2: A `start` pulse is accepted only while the block is idle. All `cfg_*` inputs are captured in the accepting cycle. A `start` pulse or a configuration change during a frame does not alter the bits emitted.
- R3: While `bit_valid` is high and `bit_ready` is low, the next cycle keeps `bit_valid` high with `bit_data` and `bit_rate` unchanged. The stream advances exactly one bit per handshake.
- R4: With `cfg_short`=0, the sync field is `cfg_sync_len` one bits. A value of 0 omits the sync field.
- R5: With `cfg_short`=1, the sync field is 56 zero bits, and `cfg_sync_len` is ignored.
- R6: The delimiter in long format is 16'hF3A0 sent least significant bit first (0000010111001111). In short format it is the same 16 bits in reverse order.
- R7: After the delimiter, the signal byte, then the service byte, then the length word are sent, each least significant bit first.
- R8: The last 16 bits are the ones-complement of a CRC register. That register uses polynomial x^16+x^12+x^5+1, is preset to all ones, and is fed the 32 header bits in transmit order. The complemented value is sent most significant bit first.
- R9: `bit_rate` is 0 for 1 Mbps and 1 for 2 Mbps. It is 0 for every bit in long format. In short format it is 0 for sync and delimiter bits and 1 for header and check bits.
- R10: `done` is high for exactly one cycle: the cycle after the handshake of the last check bit. `bit_valid` is low in that cycle, and a `start` in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| cfg_short | input | 1 | 1 selects short format |
| cfg_sync_len | input | SYNC_W | Long-format sync length in bits |
| cfg_signal | input | 8 | Signal byte |
| cfg_service | input | 8 | Service byte |
| cfg_length | input | 16 | Length word |
| busy | output | 1 | Frame in progress |
| bit_valid | output | 1 | Stream bit available |
| bit_ready | input | 1 | Consumer takes the bit |
| bit_data | output | 1 | Stream bit |
| bit_rate | output | 1 | Rate tag of the bit (0: 1 Mbps, 1: 2 Mbps) |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The hardest situations to reach from the ports are the frame boundaries. One is a new `start` landing in the very cycle of `done`. Another is a `start` landing in the middle of a frame, with different configuration presented at the same time. The stimulus issues each new frame in the `done` cycle of the previous one. It also pulses `start` with scrambled configuration a few bits into every frame, while the consumer's `bit_ready` follows always-on, alternating and pseudo-random patterns. The scoreboard expects the originally captured frame to come out unchanged.

// File: rtl/phg_pkg.sv
package phg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_SFD,
    PH_HDR,
    PH_CRC
  } phase_t;

  localparam logic [15:0] SFD_WORD  = 16'hF3A0;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam int          HDR_BITS  = 32;
  localparam int          SFD_BITS  = 16;
  localparam int          CRC_BITS  = 16;
endpackage

// File: rtl/phg_seq.sv
module phg_seq
  import phg_pkg::*;
#(
  parameter int SYNC_W     = 8,
  parameter int SHORT_SYNC = 56,
  parameter int CW         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fire,
  input  logic              cfg_short,
  input  logic [SYNC_W-1:0] cfg_sync_len,
  output phase_t            phase,
  output logic [CW-1:0]     cnt,
  output logic              short_q,
  output logic              done,
  output logic              accept
);
  logic [SYNC_W-1:0] sync_len_q;
  logic [CW-1:0]     last;
  phase_t            phase_n;
  logic [CW-1:0]     cnt_n;
  logic              at_last;

  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_SYNC - 1);
  localparam logic [CW-1:0] SFD_LAST   = CW'(SFD_BITS - 1);
  localparam logic [CW-1:0] HDR_LAST   = CW'(HDR_BITS - 1);
  localparam logic [CW-1:0] CRC_LAST   = CW'(CRC_BITS - 1);

  assign accept = start && (phase == PH_IDLE);

  always_comb begin
    unique case (phase)
      PH_SYNC: last = short_q ? SHORT_LAST : CW'(sync_len_q) - CW'(1);
      PH_SFD:  last = SFD_LAST;
      PH_HDR:  last = HDR_LAST;
      PH_CRC:  last = CRC_LAST;
      default: last = '0;
    endcase
  end

  assign at_last = (cnt == last);

  always_comb begin
    phase_n = phase;
    cnt_n   = cnt;
    if (accept) begin
      cnt_n   = '0;
      phase_n = (cfg_short || (cfg_sync_len != '0)) ? PH_SYNC : PH_SFD;
    end else if (fire && phase != PH_IDLE) begin
      if (at_last) begin
        cnt_n = '0;
        unique case (phase)
          PH_SYNC: phase_n = PH_SFD;
          PH_SFD:  phase_n = PH_HDR;
          PH_HDR:  phase_n = PH_CRC;
          default: phase_n = PH_IDLE;
        endcase
      end else begin
        cnt_n = cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      short_q    <= 1'b0;
      sync_len_q <= '0;
      done       <= 1'b0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
      done  <= fire && (phase == PH_CRC) && at_last;
      if (accept) begin
        short_q    <= cfg_short;
        sync_len_q <= cfg_sync_len;
      end
    end
  end
endmodule

// File: rtl/phg_crc.sv
module phg_crc
  import phg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic feed,
  input  logic shift,
  input  logic bit_in,
  output logic crc_bit
);
  logic [15:0] crc_q;
  logic        fb;

  assign fb      = bit_in ^ crc_q[15];
  assign crc_bit = ~crc_q[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else if (clear) begin
      crc_q <= '1;
    end else if (feed) begin
      crc_q <= {crc_q[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end else if (shift) begin
      crc_q <= {crc_q[14:0], 1'b1};
    end
  end
endmodule

// File: rtl/phg_bitsel.sv
module phg_bitsel
  import phg_pkg::*;
#(
  parameter int CW = 8
) (
  input  phase_t               phase,
  input  logic [CW-1:0]        cnt,
  input  logic                 short_q,
  input  logic [HDR_BITS-1:0]  hdr_word,
  input  logic                 crc_bit,
  output logic                 bit_data,
  output logic                 bit_rate
);
  logic [3:0] sfd_idx;
  logic [4:0] hdr_idx;

  assign sfd_idx = short_q ? 4'(15 - int'(cnt[3:0])) : cnt[3:0];
  assign hdr_idx = cnt[4:0];

  always_comb begin
    unique case (phase)
      PH_SYNC: bit_data = ~short_q;
      PH_SFD:  bit_data = SFD_WORD[sfd_idx];
      PH_HDR:  bit_data = hdr_word[hdr_idx];
      PH_CRC:  bit_data = crc_bit;
      default: bit_data = 1'b0;
    endcase
    bit_rate = short_q && (phase == PH_HDR || phase == PH_CRC);
  end
endmodule

// File: rtl/preamble_header_gen.sv
module preamble_header_gen
  import phg_pkg::*;
#(
  parameter int SYNC_W     = 8,
  parameter int SHORT_SYNC = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_short,
  input  logic [SYNC_W-1:0] cfg_sync_len,
  input  logic [7:0]        cfg_signal,
  input  logic [7:0]        cfg_service,
  input  logic [15:0]       cfg_length,
  output logic              busy,
  output logic              bit_valid,
  input  logic              bit_ready,
  output logic              bit_data,
  output logic              bit_rate,
  output logic              done
);
  localparam int CW = (SYNC_W > 6) ? SYNC_W : 6;

  phase_t              phase;
  logic [CW-1:0]       cnt;
  logic                short_q;
  logic                accept;
  logic                fire;
  logic                crc_bit;
  logic [HDR_BITS-1:0] hdr_q;

  assign bit_valid = (phase != PH_IDLE);
  assign busy      = bit_valid;
  assign fire      = bit_valid && bit_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hdr_q <= '0;
    else if (accept) hdr_q <= {cfg_length, cfg_service, cfg_signal};
  end

  phg_seq #(.SYNC_W(SYNC_W), .SHORT_SYNC(SHORT_SYNC), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .fire(fire),
    .cfg_short(cfg_short), .cfg_sync_len(cfg_sync_len),
    .phase(phase), .cnt(cnt), .short_q(short_q), .done(done), .accept(accept)
  );

  phg_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .feed(fire && phase == PH_HDR), .shift(fire && phase == PH_CRC),
    .bit_in(bit_data), .crc_bit(crc_bit)
  );

  phg_bitsel #(.CW(CW)) u_sel (
    .phase(phase), .cnt(cnt), .short_q(short_q), .hdr_word(hdr_q),
    .crc_bit(crc_bit), .bit_data(bit_data), .bit_rate(bit_rate)
  );
endmodule

// File: rtl/phg_checker.sv
module phg_checker
  import phg_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   start,
  input logic   bit_valid,
  input logic   bit_ready,
  input logic   bit_data,
  input logic   bit_rate,
  input logic   done,
  input logic   busy,
  input logic   short_q,
  input phase_t phase
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !bit_ready |=> bit_valid && $stable(bit_data) && $stable(bit_rate));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bit_valid);

  p_busy_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(bit_ready && phase == PH_CRC) |=> busy);

  p_sync_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_SYNC |-> bit_data == !short_q);

  p_long_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !short_q |-> !bit_rate);

  p_preamble_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SYNC || phase == PH_SFD) |-> !bit_rate);
endmodule

bind preamble_header_gen phg_checker u_phg_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_valid(bit_valid),
  .bit_ready(bit_ready), .bit_data(bit_data), .bit_rate(bit_rate),
  .done(done), .busy(busy), .short_q(short_q), .phase(phase)
);

// File: tb/preamble_header_gen_bench.sv
`timescale 1ns/1ps
module preamble_header_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cfg_short = 1'b0;
  logic [7:0] cfg_sync_len = 8'd0;
  logic [7:0] cfg_signal = 8'd0;
  logic [7:0] cfg_service = 8'd0;
  logic [15:0] cfg_length = 16'd0;
  logic       busy, bit_valid, bit_data, bit_rate, done;
  logic       bit_ready = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [1:0] exp_q[$];
  string cur_req = "R4";

  always #2 clk = ~clk;

  preamble_header_gen u_preamble_header_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_short(cfg_short),
    .cfg_sync_len(cfg_sync_len), .cfg_signal(cfg_signal),
    .cfg_service(cfg_service), .cfg_length(cfg_length), .busy(busy),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
    .bit_rate(bit_rate), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: sets ready, then pops and compares bits that will be taken at next edge
  always @(negedge clk) begin
    cycles++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rdy_mode)
      0: bit_ready = 1'b1;
      1: bit_ready = cycles[0];
      default: bit_ready = lfsr[0] | lfsr[2];
    endcase
    if (rst_n && bit_valid && bit_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 extra bit", 1, 0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        check(bit_data == e[0], cur_req, int'(bit_data), int'(e[0]));
        check(bit_rate == e[1], "R9 rate", int'(bit_rate), int'(e[1]));
      end
    end
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] ref_crc(input logic [31:0] w);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      logic top;
      top = r[15];
      r = r << 1;
      if (top != w[i]) r = r ^ 16'h1021;
    end
    return ~r;
  endfunction

  // driver: called at a negedge; pushes expected bits, drives start
  task automatic run_frame(input bit sh, input logic [7:0] sl, input logic [7:0] sg,
                           input logic [7:0] sv, input logic [15:0] ln, input int mode);
    logic [15:0] sfd;
    logic [31:0] hw;
    logic [15:0] c;
    int guard;
    sfd = 16'hF3A0;
    hw  = {ln, sv, sg};
    c   = ref_crc(hw);
    if (sh) for (int i = 0; i < 56; i++) exp_q.push_back(2'b00);
    else    for (int i = 0; i < int'(sl); i++) exp_q.push_back(2'b01);
    for (int i = 0; i < 16; i++) exp_q.push_back({1'b0, sh ? sfd[15-i] : sfd[i]});
    for (int i = 0; i < 32; i++) exp_q.push_back({sh, hw[i]});
    for (int i = 15; i >= 0; i--) exp_q.push_back({sh, c[i]});
    rdy_mode = mode;
    cur_req = sh ? "R5/R6/R7/R8" : "R4/R6/R7/R8";
    cfg_short = sh; cfg_sync_len = sl; cfg_signal = sg; cfg_service = sv; cfg_length = ln;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R10 done single cycle", int'(done), 0);
    check(busy == 1'b1, "R2 start taken when idle", int'(busy), 1);
    // R2: scramble config after capture, then retry start mid-frame
    cfg_short = ~sh; cfg_sync_len = sl ^ 8'h3C; cfg_signal = ~sg;
    cfg_service = ~sv; cfg_length = ~ln;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, "R10 done seen", int'(done), 1);
    check(exp_q.size() == 0, "R10 done after last bit", exp_q.size(), 0);
    check(bit_valid == 1'b0, "R10 idle in done cycle", int'(bit_valid), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bit_valid == 1'b0, "R1 valid", int'(bit_valid), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 default-length long frame, always ready
    run_frame(1'b0, 8'd128, 8'h0A, 8'h00, 16'h0100, 0);
    // R5 short frame back-to-back in done cycle (R10), alternating ready (R3)
    run_frame(1'b1, 8'd7, 8'h14, 8'h80, 16'h0035, 1);
    // R4 zero-length sync, random stalls
    run_frame(1'b0, 8'd0, 8'h37, 8'h04, 16'hBEEF, 2);
    // R4 short long-mode sync, random stalls
    run_frame(1'b0, 8'd3, 8'h6E, 8'h55, 16'h1234, 2);
    // R5 short, sync len ignored, random stalls
    run_frame(1'b1, 8'd200, 8'hFF, 8'hFF, 16'hFFFF, 2);
    // R8 all-zero header, alternating ready
    run_frame(1'b0, 8'd1, 8'h00, 8'h00, 16'h0000, 1);
    @(negedge clk);
    check(done == 1'b0, "R10 done low after pulse", int'(done), 0);
    // R3 stall: hold ready low, values must hold
    rdy_mode = 3;
    start = 1'b1; cfg_short = 1'b0; cfg_sync_len = 8'd2;
    exp_q.push_back(2'b01); exp_q.push_back(2'b01);
    @(negedge clk);
    start = 1'b0;
    begin
      logic d0, r0;
      d0 = bit_data; r0 = bit_rate;
      check(bit_valid == 1'b1, "R3 valid", int'(bit_valid), 1);
      force bit_ready = 1'b0;
      repeat (4) @(negedge clk);
      check(bit_valid && bit_data == d0 && bit_rate == r0, "R3 hold under stall",
            int'(bit_data), int'(d0));
      release bit_ready;
    end
    exp_q.delete();
    rst_n = 1'b0;
    @(negedge clk);
    check(bit_valid == 1'b0, "R1 valid after reset", int'(bit_valid), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule